// File: doc/BRIEF.md
# Multi-mode serial PCM port

This block moves voice samples between a serial PCM stream pair and a parallel word interface inside the chip. It has one serial input (`sdi`) and one serial output (`sdo`), and its own output-enable (`sdo_oe`) for the pad. The device carries two stream pairs. Each pair gets its own instance, with its own enable and mode pins, so the two pairs are framed independently.

The framing is picked automatically.

- **Strobe-framed mode.** If the frame-pulse pin `fp` stays low from reset, the port works in strobe-framed mode. A high level on `en` then brackets the transfer. The strobe is 8 or 16 bit clocks wide and occurs once per 125 µs frame. The bit clock is synchronous with the strobe and runs from 128 kHz to 4.096 MHz.
- **TDM mode.** Once `fp` is seen high, the port switches to TDM mode for good, until the next reset. The clock is then 4.096 MHz, which is twice the bit rate. The channel is located at a fixed slot offset from the frame pulse. The `md` pin selects whether that pulse is active low or active high. The `en` pin selects an 8-bit or 16-bit slot.

Serial bits are sent and received MSB first. Output bits change after the rising clock edge and input bits are taken on the falling edge. Words to send are taken from `tx_data` when their first bit launches. A received word is presented on `rx_data` with a one-cycle `rx_valid` pulse. An 8-bit word is left-justified in that output.

Top module: `pcm_serial_port`

## Requirements
- R1: After reset the port is in strobe-framed mode; the first rising edge at which `fp` is high switches it to TDM mode, where it stays until the next reset, and `en` then no longer acts as a strobe.
- R2: In strobe-framed mode, the k-th rising edge with `en` high (k counted from 0) drives bit 15-k of the captured word on `sdo` with `sdo_oe` high during the following cycle (MSB first); from the 17th strobe cycle on, `sdo_oe` stays low.
- R3: Input bits are taken from `sdi` on falling clock edges inside driven bit cycles, MSB first, so the first received bit ends up as the word's most significant bit.
- R4: A strobe of exactly 8 or 16 cycles produces `rx_valid` in the cycle after the first rising edge with `en` low. For 16 cycles, `rx_data` is the full word and `rx_wide`=1. For 8 cycles, `rx_data[15:8]` holds the byte, `rx_data[7:0]`=0 and `rx_wide`=0.
- R5: A strobe of any other length produces no `rx_valid`.
- R6: `tx_data` is captured on the rising edge that launches a word's first bit; later changes to `tx_data` do not alter the word being sent.
- R7: In TDM mode, with `md`=0 the frame pulse is `fp` low at a rising edge, and with `md`=1 it is `fp` high. The `en` level at the frame pulse selects a 16-bit slot (1) or an 8-bit slot (0) for that frame.
- R8: In TDM mode, the cycle after the frame-pulse edge is cycle 0. Each bit spans two clock cycles. `sdo_oe` is high from cycle 16·SLOT for 16 (8-bit) or 32 (16-bit) cycles, with bit j of the slot driven in cycles 16·SLOT+2j and 16·SLOT+2j+1. Input bit j is taken on the falling edge of the second of those cycles.
- R9: In TDM mode, `rx_valid` is high in the cycle right after the slot's last cycle, with the received word laid out as in R4.
- R10: `rx_valid` lasts exactly one cycle. `sdo` is low whenever `sdo_oe` is low. In TDM mode, nothing is driven before the first frame pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock (strobe mode) or 2x bit-rate clock (TDM mode) |
| rst_n | input | 1 | Asynchronous active-low reset |
| fp | input | 1 | Frame pulse; tie low for strobe-framed mode |
| en | input | 1 | Strobe in strobe mode; slot width select in TDM mode |
| md | input | 1 | TDM frame-pulse polarity select |
| sdi | input | 1 | Serial data input |
| sdo | output | 1 | Serial data output |
| sdo_oe | output | 1 | Output enable for the serial data pad |
| tx_data | input | 16 | Word to transmit, MSB first |
| rx_data | output | 16 | Last received word, 8-bit words left-justified |
| rx_valid | output | 1 | One-cycle pulse when a new word is on rx_data |
| rx_wide | output | 1 | Received word was 16 bits |

## Verification
Some properties are checked on every cycle:
- `rx_valid` is a single-cycle pulse that never overlaps a driven bit.
- An 8-bit word always arrives with a zero low byte.
- While `fp` has never been high, `sdo_oe` only follows a cycle with `en` high.
- No driven run exceeds two bit-lengths of a full word.

Other behaviour can only be shown by the bench's scenarios:
- The exact bit order, and the slot position relative to the frame pulse.
- The capture of `tx_data` at the first bit.
- Both pulse polarities, and the rejection of odd strobe lengths.
- The permanent switch into TDM mode and the return to strobe mode after reset.

// File: rtl/pcm_serial_port.sv
module pcm_serial_port #(
  parameter int DW   = 16,
  parameter int SLOT = 2,
  parameter int HCW  = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fp,
  input  logic          en,
  input  logic          md,
  input  logic          sdi,
  output logic          sdo,
  output logic          sdo_oe,
  input  logic [DW-1:0] tx_data,
  output logic [DW-1:0] rx_data,
  output logic          rx_valid,
  output logic          rx_wide
);
  localparam int HW = DW / 2;
  localparam int IW = $clog2(DW);
  localparam int CW = IW + 2;
  localparam logic [CW-1:0]  CMAX  = '1;
  localparam logic [CW-1:0]  C_W   = CW'(DW);
  localparam logic [CW-1:0]  C_N   = CW'(HW);
  localparam logic [HCW-1:0] HMAX  = '1;
  localparam logic [HCW-1:0] S0    = HCW'(SLOT * DW);
  localparam logic [HCW-1:0] LEN_N = HCW'(DW);
  localparam logic [HCW-1:0] LEN_W = HCW'(2 * DW);

  logic           tdm_q, sync_q, wide_q, st_act;
  logic [CW-1:0]  cnt, sbit, bidx;
  logic [HCW-1:0] hc, hc_n, len, rel;
  logic [DW-1:0]  tx_hold, rx_sr;
  logic [IW-1:0]  ix;

  // frame pulse decode and TDM position
  wire fp_act  = md ? fp : ~fp;
  wire tdm_eff = tdm_q | fp;
  wire pulse   = tdm_eff & fp_act;

  assign hc_n = pulse ? '0 : ((hc == HMAX) ? hc : hc + 1'b1);
  assign len  = wide_q ? LEN_W : LEN_N;
  assign rel  = hc - S0;

  wire in_slot  = sync_q && (hc >= S0) && (rel < len);
  wire ld_tdm   = (pulse | sync_q) && (hc_n == S0);
  wire done_tdm = tdm_q && sync_q && !pulse && (hc == S0 + len - 1'b1);

  // shared output path
  wire drv  = tdm_q ? in_slot : (st_act && (sbit < C_W));
  wire samp = drv & (~tdm_q | hc[0]);

  assign bidx   = tdm_q ? rel[CW:1] : sbit;
  assign ix     = IW'(DW - 1) - bidx[IW-1:0];
  assign sdo_oe = drv;
  assign sdo    = drv & tx_hold[ix];

  wire [DW-1:0] rx_word_w = rx_sr;
  wire [DW-1:0] rx_word_n = {rx_sr[HW-1:0], {HW{1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tdm_q    <= 1'b0;
      sync_q   <= 1'b0;
      wide_q   <= 1'b0;
      hc       <= '0;
      st_act   <= 1'b0;
      cnt      <= '0;
      sbit     <= '0;
      tx_hold  <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
      rx_wide  <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (fp) tdm_q <= 1'b1;
      if (tdm_eff) begin
        st_act <= 1'b0;
        cnt    <= '0;
        hc     <= hc_n;
        if (pulse) begin
          sync_q <= 1'b1;
          wide_q <= en;
        end
        if (ld_tdm) tx_hold <= tx_data;
        if (done_tdm) begin
          rx_valid <= 1'b1;
          rx_wide  <= wide_q;
          rx_data  <= wide_q ? rx_word_w : rx_word_n;
        end
      end else if (en) begin
        st_act <= 1'b1;
        sbit   <= cnt;
        if (cnt != CMAX) cnt <= cnt + 1'b1;
        if (cnt == '0) tx_hold <= tx_data;
      end else begin
        st_act <= 1'b0;
        cnt    <= '0;
        if (cnt == C_W || cnt == C_N) begin
          rx_valid <= 1'b1;
          rx_wide  <= (cnt == C_W);
          rx_data  <= (cnt == C_W) ? rx_word_w : rx_word_n;
        end
      end
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) rx_sr <= '0;
    else if (samp) rx_sr <= {rx_sr[DW-2:0], sdi};
  end
endmodule

module pcm_serial_port_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fp,
  input logic          en,
  input logic          sdo_oe,
  input logic [DW-1:0] rx_data,
  input logic          rx_valid,
  input logic          rx_wide
);
  logic       seen;
  logic [7:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen <= 1'b0;
      run  <= '0;
    end else begin
      if (fp) seen <= 1'b1;
      run <= sdo_oe ? run + 1'b1 : '0;
    end
  end

  // R10
  rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R9
  valid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !sdo_oe);

  // R4
  narrow_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_wide) |-> (rx_data[DW/2-1:0] == '0));

  // R1
  strobe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!seen && !fp && !en) |=> !sdo_oe);

  // R2
  strobe_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!seen && sdo_oe) |-> $past(en));

  // R8
  oe_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_oe |-> (run < 8'(2 * DW)));
endmodule

bind pcm_serial_port pcm_serial_port_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fp(fp), .en(en), .sdo_oe(sdo_oe),
  .rx_data(rx_data), .rx_valid(rx_valid), .rx_wide(rx_wide)
);

// File: tb/tb_pcm_serial_port.sv
`timescale 1ns/1ps
module tb_pcm_serial_port;
  localparam int S = 32;

  logic clk = 1'b0, rst_n = 1'b0, fp = 1'b0, en = 1'b0, md = 1'b0, sdi = 1'b0;
  logic [15:0] tx_data = '0;
  logic sdo, sdo_oe, rx_valid, rx_wide;
  logic [15:0] rx_data;
  int tests = 0, fails = 0;

  always #2 clk = ~clk;

  pcm_serial_port #(.DW(16), .SLOT(2), .HCW(10)) dut (
    .clk(clk), .rst_n(rst_n), .fp(fp), .en(en), .md(md), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .tx_data(tx_data), .rx_data(rx_data),
    .rx_valid(rx_valid), .rx_wide(rx_wide));

  function automatic logic [15:0] exp_rx(input int n, input logic [15:0] w);
    return (n == 16) ? w : {w[15:8], 8'h00};
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(posedge clk); #3;
    rst_n = 1'b0; fp = 1'b0; en = 1'b0; md = 1'b0; sdi = 1'b0;
    repeat (3) @(posedge clk);
    #3 rst_n = 1'b1;
  endtask

  task automatic strobe_xfer(input int n, input logic [15:0] txw, input logic [15:0] rxw);
    logic ok;
    tx_data = txw;
    @(posedge clk); #3 en = 1'b1;
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
      chk("R2", "strobe oe", sdo_oe, k < 16);
      chk("R2,R6", "strobe sdo", sdo, (k < 16) ? txw[15-k] : 1'b0);
      chk("R10", "valid idle", rx_valid, 0);
      if (k == 0) tx_data = ~txw;
      sdi = (k < 16) ? rxw[15-k] : 1'($urandom);
      if (k == n - 1) #2 en = 1'b0;
    end
    @(posedge clk); #1;
    ok = (n == 8 || n == 16);
    chk(ok ? "R4" : "R5", "strobe valid", rx_valid, ok);
    if (ok) begin
      chk("R3", "strobe rx_data", rx_data, exp_rx(n, rxw));
      chk("R4", "strobe rx_wide", rx_wide, n == 16);
    end
    chk("R2", "oe after strobe", sdo_oe, 0);
    @(posedge clk); #1;
    chk("R10", "valid pulse end", rx_valid, 0);
  endtask

  task automatic tdm_frame(input logic pol, input logic wide,
                           input logic [15:0] txw, input logic [15:0] rxw);
    int len;
    len = wide ? 32 : 16;
    @(posedge clk); #3;
    md = pol; en = wide; fp = ~pol; tx_data = txw;
    @(posedge clk); #3 fp = pol;
    for (int c = 0; c <= S + len + 1; c++) begin
      logic ins;
      int b;
      @(posedge clk); #1;
      ins = (c >= S) && (c < S + len);
      b = (c - S) / 2;
      chk("R8", "tdm oe", sdo_oe, ins);
      chk("R8", "tdm sdo", sdo, ins ? txw[15-b] : 1'b0);
      chk("R9", "tdm valid", rx_valid, c == S + len);
      if (c == S + len) begin
        chk("R9", "tdm rx_data", rx_data, exp_rx(wide ? 16 : 8, rxw));
        chk("R7", "tdm rx_wide", rx_wide, wide);
      end
      if (c == S) tx_data = ~txw;
      sdi = ins ? rxw[15-b] : 1'($urandom);
      if (c == 0) begin
        #2 fp = ~pol;
        en = ~wide;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    do_reset();
    @(posedge clk); #1;
    chk("R10", "reset oe", sdo_oe, 0);
    chk("R10", "reset valid", rx_valid, 0);
    chk("R10", "reset rx_data", rx_data, 0);

    strobe_xfer(8, 16'hA5C3, 16'h3C00);
    strobe_xfer(16, 16'h8001, 16'hB66D);
    strobe_xfer(5, 16'hFFFF, 16'h1234);
    strobe_xfer(12, 16'h0F0F, 16'hCAFE);
    strobe_xfer(20, 16'h7E81, 16'h9191);
    strobe_xfer(1, 16'h8000, 16'h8000);
    for (int i = 0; i < 24; i++) begin
      int sel, n;
      sel = $urandom_range(0, 3);
      n = (sel == 0) ? 8 : (sel == 1) ? 16 : $urandom_range(1, 20);
      strobe_xfer(n, 16'($urandom), 16'($urandom));
    end

    @(posedge clk); #3 md = 1'b0; fp = 1'b1; en = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(posedge clk); #1;
      chk("R10", "unsynced tdm oe", sdo_oe, 0);
      chk("R1", "en no strobe in tdm", rx_valid, 0);
    end

    tdm_frame(1'b0, 1'b1, 16'hD00D, 16'h5A5A);
    tdm_frame(1'b0, 1'b0, 16'h93FF, 16'hE700);
    for (int i = 0; i < 8; i++)
      tdm_frame(1'b0, 1'($urandom), 16'($urandom), 16'($urandom));

    do_reset();
    tdm_frame(1'b1, 1'b0, 16'h6C00, 16'h81FF);
    tdm_frame(1'b1, 1'b1, 16'h0001, 16'hFFFE);
    for (int i = 0; i < 12; i++)
      tdm_frame(1'($urandom), 1'($urandom), 16'($urandom), 16'($urandom));

    do_reset();
    strobe_xfer(16, 16'h4BD2, 16'h2DB4);
    strobe_xfer(8, 16'hC300, 16'h7100);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule